// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the control and status state for each channel of a multi-channel DMA controller, four channels by default. Each channel has one 8-bit register on a simple bus with separate read and write strobes. The register carries a channel enable, a mode that keeps the channel enabled across terminal count, a completion flag, and two write-one commands. One command starts a transfer from software. The other forces the current transfer to end.

The transfer engine reports three things per channel: a terminal-count event, a suspended indication, and a global non-maskable interrupt. Peripherals raise hardware transfer requests. For each channel the block drives three outputs back to the engine: the enable level, a one-cycle start pulse, and a one-cycle abort pulse.

The completion flag is cleared by reading the register. While the flag is set, a software start is refused. Hardware requests are also refused while the flag is set, except in keep-enabled mode.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every channel register reads 0x00 and `chan_en`, `start_pulse` and `abort_pulse` are all 0.
- R2: Channel n's register sits at byte offset 2n. Its bit layout is: bit 7 completion flag, bit 3 keep-enabled mode, bit 2 abort command, bit 1 start command, bit 0 enable. Bits 6 to 4, 2 and 1 always read as 0. Reads from an odd offset return 0x00, and writes to an odd offset change nothing.
- R3: A terminal-count event sets the completion flag. A read of the register clears the flag on the following edge. When an event and a read fall in the same cycle, the flag stays 1. Writing bit 7 has no effect.
- R4: On a terminal-count event with keep-enabled mode 0, the enable is cleared. This takes priority over a write in the same cycle.
- R5: On a terminal-count event with keep-enabled mode 1, the enable stays 1. A hardware request is still accepted while the completion flag is 1.
- R6: A hardware request is accepted only when the enable is 1 and either the completion flag is 0 or keep-enabled mode is 1. The start pulse appears one cycle after acceptance.
- R7: A write with bit 1 set starts the channel only when, before the write, the enable is 1 and the completion flag is 0, and bit 2 of the same write is 0. The start pulse appears one cycle later.
- R8: A write with bit 2 set clears the enable. It produces an abort pulse one cycle later only if the channel was enabled or `susp` was high for it. Otherwise no abort pulse is produced.
- R9: A high `nmi` clears the enable of every channel. This takes priority over any write in the same cycle.
- R10: Bit 0 of a write loads the enable. Rewriting 1 to an enabled channel leaves its state unchanged and produces no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears the completion flag of the addressed channel |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| hw_req | input | NCH | Hardware transfer request per channel |
| susp | input | NCH | Channel suspended, from the transfer engine |
| tc_evt | input | NCH | Terminal-count event per channel |
| nmi | input | 1 | Non-maskable interrupt; disables all channels |
| chan_en | output | NCH | Channel enable level |
| start_pulse | output | NCH | One-cycle transfer start to the engine |
| abort_pulse | output | NCH | One-cycle forced termination to the engine |

## Verification
The assertions assume a few things about the inputs:
- A terminal-count event arrives on its own channel.
- `rst` is sampled synchronously.
- Read and write strobes are single-cycle qualifiers sampled at the edge.

The assertions do not assume that a write and a read never coincide. The stimulus honours these assumptions by driving every input at the falling edge, one step per cycle. It raises terminal-count events from a per-channel count model that reloads when a channel becomes enabled and counts down on each observed start. Sparse random terminal-count events and random bus traffic are added on top. Any mix of write, read, hardware request, suspend and `nmi` in the same cycle stays legal.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    // Bit positions inside each 8-bit channel register
    localparam int REG_W     = 8;
    localparam int POS_DONE  = 7;
    localparam int POS_KEEP  = 3;
    localparam int POS_ABORT = 2;
    localparam int POS_START = 1;
    localparam int POS_EN    = 0;
    localparam int CMD_W     = POS_KEEP + 1;

    // Stored per-channel state
    typedef struct packed {
        logic done;
        logic keep;
        logic en;
    } chan_state_t;

    // Per-channel bus command after address decode
    typedef struct packed {
        logic wr;
        logic rd;
        logic en;
        logic keep;
        logic abort;
        logic start;
    } chan_cmd_t;

    function automatic logic [REG_W-1:0] pack_status(chan_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[POS_DONE] = s.done;
        r[POS_KEEP] = s.keep;
        r[POS_EN]   = s.en;
        return r;
    endfunction

    function automatic chan_cmd_t make_cmd(logic wr, logic rd, logic [CMD_W-1:0] d);
        chan_cmd_t c;
        c.wr    = wr;
        c.rd    = rd;
        c.en    = d[POS_EN];
        c.keep  = d[POS_KEEP];
        c.abort = d[POS_ABORT];
        c.start = d[POS_START];
        return c;
    endfunction

endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
    import dma_ctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [CMD_W-1:0]            wdata,
    input  logic [NCH-1:0][REG_W-1:0]   status,
    output chan_cmd_t                   cmd [NCH],
    output logic [REG_W-1:0]            rdata
);

    logic [NCH-1:0] sel;

    for (genvar n = 0; n < NCH; n++) begin : g_sel
        assign sel[n] = (bus_addr == ADDR_W'(2 * n));
        assign cmd[n] = make_cmd(bus_wr & sel[n], bus_rd & sel[n], wdata);
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (sel[n]) rdata = rdata | status[n];
        end
    end

endmodule

// File: rtl/dma_chan_unit.sv
module dma_chan_unit
    import dma_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cmd_t        cmd,
    input  logic             hw_req,
    input  logic             susp,
    input  logic             tc_evt,
    input  logic             nmi,
    output logic             en,
    output logic             keep,
    output logic             done,
    output logic             start_pulse,
    output logic             abort_pulse,
    output logic [REG_W-1:0] status
);

    chan_state_t st_q, st_d;
    logic        take_hw, take_sw, do_abort;
    logic        start_q, abort_q;

    assign take_hw  = hw_req & st_q.en & (~st_q.done | st_q.keep);
    assign take_sw  = cmd.wr & cmd.start & ~cmd.abort & st_q.en & ~st_q.done;
    assign do_abort = cmd.wr & cmd.abort;

    always_comb begin
        st_d = st_q;
        // enable: nmi > abort > terminal count (non-keep) > write
        if (cmd.wr) begin
            st_d.keep = cmd.keep;
            st_d.en   = cmd.en;
        end
        if (tc_evt && !st_q.keep) st_d.en = 1'b0;
        if (do_abort)             st_d.en = 1'b0;
        if (nmi)                  st_d.en = 1'b0;
        // completion flag: set beats read-clear
        if (cmd.rd)  st_d.done = 1'b0;
        if (tc_evt)  st_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_q <= take_hw | take_sw;
            abort_q <= do_abort & (st_q.en | susp);
        end
    end

    assign en          = st_q.en;
    assign keep        = st_q.keep;
    assign done        = st_q.done;
    assign start_pulse = start_q;
    assign abort_pulse = abort_q;
    assign status      = pack_status(st_q);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_ctl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(2 * NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH-1:0]    susp,
    input  logic [NCH-1:0]    tc_evt,
    input  logic              nmi,
    output logic [NCH-1:0]    chan_en,
    output logic [NCH-1:0]    start_pulse,
    output logic [NCH-1:0]    abort_pulse
);

    chan_cmd_t                  cmd [NCH];
    logic [NCH-1:0][REG_W-1:0]  status;
    logic [NCH-1:0]             keep_vec;
    logic [NCH-1:0]             done_vec;
    logic [NCH-1:0]             rd_hit;

    dma_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wdata    (bus_wdata[CMD_W-1:0]),
        .status   (status),
        .cmd      (cmd),
        .rdata    (bus_rdata)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign rd_hit[n] = cmd[n].rd;
        dma_chan_unit u_ch (
            .clk         (clk),
            .rst         (rst),
            .cmd         (cmd[n]),
            .hw_req      (hw_req[n]),
            .susp        (susp[n]),
            .tc_evt      (tc_evt[n]),
            .nmi         (nmi),
            .en          (chan_en[n]),
            .keep        (keep_vec[n]),
            .done        (done_vec[n]),
            .start_pulse (start_pulse[n]),
            .abort_pulse (abort_pulse[n]),
            .status      (status[n])
        );
    end

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_wr,
    input logic [7:0]     bus_wdata,
    input logic [7:0]     bus_rdata,
    input logic [NCH-1:0] hw_req,
    input logic [NCH-1:0] tc_evt,
    input logic           nmi,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] start_pulse,
    input logic [NCH-1:0] abort_pulse,
    input logic [NCH-1:0] keep_vec,
    input logic [NCH-1:0] done_vec,
    input logic [NCH-1:0] rd_hit
);

    // R2: reserved and command bits never read back as 1
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_wdata[7:4] != 4'h0)) |=> ((bus_rdata & 8'h76) == 8'h00));

    // R9: nmi disables every channel
    p_nmi_all_off_r9: assert property (@(posedge clk) disable iff (rst)
        nmi |=> (chan_en == '0));

    for (genvar n = 0; n < NCH; n++) begin : g_p
        // R3: a terminal-count event always leaves the flag set
        p_done_set_r3: assert property (@(posedge clk) disable iff (rst)
            tc_evt[n] |=> done_vec[n]);
        // R3: a read without a concurrent event clears the flag
        p_done_rdclr_r3: assert property (@(posedge clk) disable iff (rst)
            (rd_hit[n] && !tc_evt[n]) |=> !done_vec[n]);
        // R4: terminal count in normal mode drops the enable
        p_tc_disable_r4: assert property (@(posedge clk) disable iff (rst)
            (tc_evt[n] && !keep_vec[n]) |=> !chan_en[n]);
        // R5: keep-enabled mode accepts hardware requests regardless of the flag
        p_keep_hw_r5: assert property (@(posedge clk) disable iff (rst)
            (hw_req[n] && chan_en[n] && keep_vec[n]) |=> start_pulse[n]);
        // R6 / R7: a start only follows an enabled cycle
        p_start_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
            start_pulse[n] |-> $past(chan_en[n]));
        // R8: an abort pulse coincides with a disabled channel
        p_abort_off_r8: assert property (@(posedge clk) disable iff (rst)
            abort_pulse[n] |-> !chan_en[n]);
    end

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .hw_req      (hw_req),
    .tc_evt      (tc_evt),
    .nmi         (nmi),
    .chan_en     (chan_en),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .keep_vec    (keep_vec),
    .done_vec    (done_vec),
    .rd_hit      (rd_hit)
);

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, nmi = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] hw_req = '0, susp = '0, tc_evt = '0;
    logic [3:0] chan_en, start_pulse, abort_pulse;

    always #2 clk = ~clk;

    dma_chan_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_req(hw_req), .susp(susp),
        .tc_evt(tc_evt), .nmi(nmi), .chan_en(chan_en), .start_pulse(start_pulse),
        .abort_pulse(abort_pulse)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [3:0] m_en = '0, m_keep = '0, m_done = '0, tc_pend = '0;
    int cnt [4] = '{0, 0, 0, 0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        int c;
        if (a[0]) return 8'h00;
        c = int'(a[2:1]);
        return {m_done[c], 3'b000, m_keep[c], 2'b00, m_en[c]};
    endfunction

    // One cycle: drive at negedge, check read data, advance model, check outputs at next negedge.
    task automatic step(input string tag, input logic wr, input logic rd, input logic [2:0] a,
                        input logic [7:0] d, input logic [3:0] hw, input logic [3:0] su,
                        input logic nm, input logic [3:0] tc_extra);
        logic [3:0] tcv, e_start, e_abort, n_en, n_keep, n_done;
        tcv = tc_pend | tc_extra;
        tc_pend = '0;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        hw_req = hw; susp = su; nmi = nm; tc_evt = tcv;
        #1;
        chk({tag, " R2 R3 rdata"}, 32'(bus_rdata), 32'(exp_read(a)));
        for (int n = 0; n < 4; n++) begin
            logic hit, w, r;
            hit = (a == 3'(2 * n));
            w = wr & hit;
            r = rd & hit;
            e_start[n] = (hw[n] & m_en[n] & (~m_done[n] | m_keep[n])) |
                         (w & d[1] & ~d[2] & m_en[n] & ~m_done[n]);
            e_abort[n] = w & d[2] & (m_en[n] | su[n]);
            n_en[n] = m_en[n];
            n_keep[n] = m_keep[n];
            if (w) begin n_keep[n] = d[3]; n_en[n] = d[0]; end
            if (tcv[n] && !m_keep[n]) n_en[n] = 1'b0;
            if (w && d[2]) n_en[n] = 1'b0;
            if (nm) n_en[n] = 1'b0;
            n_done[n] = m_done[n];
            if (r) n_done[n] = 1'b0;
            if (tcv[n]) n_done[n] = 1'b1;
            // transfer count model
            if (!m_en[n] && n_en[n]) cnt[n] = 1 + int'($urandom % 3);
            if (e_start[n] && cnt[n] > 0) begin
                cnt[n]--;
                if (cnt[n] == 0) begin
                    tc_pend[n] = 1'b1;
                    cnt[n] = m_keep[n] ? 2 : 0;
                end
            end
        end
        m_en = n_en; m_keep = n_keep; m_done = n_done;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R4 R9 R10 chan_en"}, 32'(chan_en), 32'(m_en));
        chk({tag, " R6 R7 start_pulse"}, 32'(start_pulse), 32'(e_start));
        chk({tag, " R8 abort_pulse"}, 32'(abort_pulse), 32'(e_abort));
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 3'd1, 8'h00, 4'h0, 4'h0, 0, 4'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 chan_en", 32'(chan_en), 0);
        chk("R1 start_pulse", 32'(start_pulse), 0);
        chk("R1 abort_pulse", 32'(abort_pulse), 0);
        for (int c = 0; c < 4; c++) step("R1", 0, 1, 3'(2 * c), 8'h00, 0, 0, 0, 0);

        // R10 / R7: enable, software start, re-enable has no effect
        step("R10", 1, 0, 3'd0, 8'h01, 0, 0, 0, 0);
        step("R7", 1, 0, 3'd0, 8'h03, 0, 0, 0, 0);
        step("R10", 1, 0, 3'd0, 8'h01, 0, 0, 0, 0);
        chk("R10 no restart", 32'(start_pulse), 0);

        // R4 / R3 / R6: normal-mode terminal count
        step("R4", 1, 0, 3'd2, 8'h01, 0, 0, 0, 0);
        step("R4", 1, 0, 3'd2, 8'h01, 0, 0, 0, 4'b0010);
        chk("R4 ch1 disabled", 32'(chan_en[1]), 0);
        step("R6", 0, 0, 3'd1, 8'h00, 4'b0010, 0, 0, 0);
        chk("R6 refused when disabled", 32'(start_pulse[1]), 0);
        step("R3", 0, 1, 3'd2, 8'h00, 0, 0, 0, 0);
        step("R3", 0, 1, 3'd2, 8'h80, 0, 0, 0, 0);

        // R5 / R7: keep-enabled mode
        step("R5", 1, 0, 3'd4, 8'h09, 0, 0, 0, 0);
        step("R5", 0, 0, 3'd1, 8'h00, 0, 0, 0, 4'b0100);
        chk("R5 stays enabled", 32'(chan_en[2]), 1);
        step("R5", 0, 0, 3'd1, 8'h00, 4'b0100, 0, 0, 0);
        chk("R5 hw while flag set", 32'(start_pulse[2]), 1);
        step("R7", 1, 0, 3'd4, 8'h0B, 0, 0, 0, 0);
        chk("R7 sw refused while flag set", 32'(start_pulse[2]), 0);
        step("R7", 0, 1, 3'd4, 8'h00, 0, 0, 0, 0);
        step("R7", 1, 0, 3'd4, 8'h0B, 0, 0, 0, 0);
        chk("R7 sw after clear", 32'(start_pulse[2]), 1);

        // R3: set wins over read
        step("R3", 0, 1, 3'd6, 8'h00, 0, 0, 0, 4'b1000);
        step("R3", 1, 0, 3'd6, 8'h00, 0, 0, 0, 0);
        step("R3", 0, 0, 3'd6, 8'h00, 0, 0, 0, 0);

        // R8: abort with and without activity
        step("R8", 1, 0, 3'd0, 8'h01, 0, 0, 0, 0);
        step("R8", 1, 0, 3'd0, 8'h04, 0, 0, 0, 0);
        chk("R8 abort when enabled", 32'(abort_pulse[0]), 1);
        step("R8", 1, 0, 3'd0, 8'h04, 0, 0, 0, 0);
        chk("R8 no abort when idle", 32'(abort_pulse[0]), 0);
        step("R8", 1, 0, 3'd0, 8'h04, 0, 4'b0001, 0, 0);
        chk("R8 abort when suspended", 32'(abort_pulse[0]), 1);

        // R9: nmi against a concurrent write
        for (int c = 0; c < 4; c++) step("R9", 1, 0, 3'(2 * c), 8'h01, 0, 0, 0, 0);
        step("R9", 1, 0, 3'd2, 8'h01, 0, 0, 1, 0);
        chk("R9 all disabled", 32'(chan_en), 0);

        // R2: odd offsets and reserved bits
        step("R2", 1, 0, 3'd3, 8'hFF, 0, 0, 0, 0);
        step("R2", 0, 1, 3'd5, 8'h00, 0, 0, 0, 0);
        step("R2", 1, 0, 3'd6, 8'hFB, 0, 0, 0, 0);
        step("R2", 0, 0, 3'd6, 8'h00, 0, 0, 0, 0);
        idle("R2");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            logic [3:0] te;
            d = 8'($urandom) & (($urandom % 6 == 0) ? 8'hFF : 8'hFB);
            te = ($urandom % 25 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
            step("RND", ($urandom % 3) == 0, ($urandom % 4) == 0, 3'($urandom),
                 d, 4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom),
                 ($urandom % 120) == 0, te);
        end
        finish_run();
    end

endmodule